// File: doc/BRIEF.md
# Sequential Integer Divider with Remainder

This block is a multi-cycle integer divider for an XLEN-bit datapath (64 by default). One request carries two operands and three control bits: whether the quotient or the remainder is wanted, whether the operands are signed, and whether the operation is a narrow "word" variant. A word variant reads only the low WLEN bits (32 by default) of each operand and returns a sign-extended WLEN-bit result. The datapath produces one quotient bit per clock on operand magnitudes, then applies the signs in a final fix-up cycle.

Division by zero and the single signed overflow case give fixed results and raise no exception. The unit keeps the operands and both results of its last division. When a divide and a remainder on the same operands follow each other, the second one is served from that store in a single cycle without running the division again.

Top module: `seq_divider`

## Requirements
- R1: Unsigned full-width operation (op_signed=0, word_mode=0, opb nonzero) returns floor(opa/opb) when op_rem=0 and opa mod opb when op_rem=1.
- R2: Signed full-width operation truncates the quotient toward zero, and the remainder carries the sign of the dividend.
- R3: With a full-width divisor of zero, the quotient result has every bit set (signed or unsigned) and the remainder result equals opa.
- R4: A signed full-width division of the most negative value by -1 returns the dividend as quotient and zero as remainder.
- R5: With word_mode=1, only bits [WLEN-1:0] of each operand are used, read as signed or unsigned according to op_signed, and the WLEN-bit result is sign-extended from bit WLEN-1 to XLEN bits.
- R6: A word-mode divide by zero (low WLEN bits of opb all zero) returns all ones as quotient and, as remainder, the low WLEN bits of opa sign-extended.
- R7: After reset busy, done and result are zero. A division that runs the datapath raises busy on the edge that accepts start and shows done exactly XLEN+2 edges (word mode: WLEN+2) after that edge, counting it. busy and done are never high together.
- R8: start is accepted only on an edge where busy is low. A start raised while busy is high, including during the final fix-up cycle, is ignored and does not disturb the running division.
- R9: result and done hold their values until the next accepted start.
- R10: If an accepted start carries the same opa, opb, op_signed and word_mode as the last completed division, the requested result appears with done high on that very edge and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled when busy is low |
| op_rem | input | 1 | 1 selects the remainder, 0 the quotient |
| op_signed | input | 1 | 1 treats the operands as two's-complement |
| word_mode | input | 1 | 1 uses the low WLEN bits and sign-extends the result |
| opa | input | XLEN | Dividend |
| opb | input | XLEN | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | result holds the answer to the last accepted request |
| result | output | XLEN | Registered quotient or remainder |

## Verification
Two events can fall on one clock edge: the fix-up edge that retires a division, and a new request. The bench holds start high across the fix-up cycle and expects that request to be dropped, with the old result appearing on time. The second case is a stored-result hit against a fresh operand capture. The sweeps issue quotient and remainder back to back on the same operands and then change only the signedness. The first of these pairs must finish in one cycle and the second must take the full latency. Every result is compared with an arithmetic model in the bench.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIX
  } div_state_t;
endpackage

// File: rtl/div_prep.sv
// Operand conditioning: narrows word operands, takes magnitudes, flags signs.
module div_prep #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sgn,
  input  logic            word,
  output logic [XLEN-1:0] dvd_mag,
  output logic [XLEN-1:0] dvs_mag,
  output logic            neg_q,
  output logic            neg_r,
  output logic            zero_dvs
);
  localparam int XW = XLEN - WLEN;
  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

  logic [XLEN-1:0] a_ext, b_ext, a_abs, b_abs;
  logic            a_neg, b_neg;

  always_comb begin
    if (word) begin
      a_ext = {{XW{sgn & a[WLEN-1]}}, a[WLEN-1:0]};
      b_ext = {{XW{sgn & b[WLEN-1]}}, b[WLEN-1:0]};
    end else begin
      a_ext = a;
      b_ext = b;
    end
    a_neg    = sgn & a_ext[XLEN-1];
    b_neg    = sgn & b_ext[XLEN-1];
    a_abs    = a_neg ? ((~a_ext) + ONE) : a_ext;
    b_abs    = b_neg ? ((~b_ext) + ONE) : b_ext;
    zero_dvs = (b_ext == '0);
    // word operands are pre-shifted so the MSB-first loop starts at bit WLEN-1
    dvd_mag  = word ? (a_abs << XW) : a_abs;
    dvs_mag  = b_abs;
    // a zero divisor keeps the all-ones quotient unsigned-looking
    neg_q    = (a_neg ^ b_neg) & ~zero_dvs;
    neg_r    = a_neg;
  end
endmodule

// File: rtl/div_core.sv
// Restoring shift-subtract loop, one quotient bit per step.
module div_core #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            step,
  input  logic [XLEN-1:0] dvd,
  input  logic [XLEN-1:0] dvs,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem
);
  logic [XLEN-1:0] d_q, r_q, s_q;
  logic [XLEN:0]   trial, diff;
  logic            fit;

  always_comb begin
    trial = {r_q, d_q[XLEN-1]};
    diff  = trial - {1'b0, s_q};
    fit   = ~diff[XLEN];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q <= '0;
      r_q <= '0;
      s_q <= '0;
    end else if (load) begin
      d_q <= dvd;
      r_q <= '0;
      s_q <= dvs;
    end else if (step) begin
      r_q <= fit ? diff[XLEN-1:0] : trial[XLEN-1:0];
      d_q <= {d_q[XLEN-2:0], fit};
    end
  end

  assign quo = d_q;
  assign rem = r_q;
endmodule

// File: rtl/div_fix.sv
// Sign restoration and word-result sign extension.
module div_fix #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] quo,
  input  logic [XLEN-1:0] rem,
  input  logic            neg_q,
  input  logic            neg_r,
  input  logic            word,
  output logic [XLEN-1:0] q_out,
  output logic [XLEN-1:0] r_out
);
  localparam int XW = XLEN - WLEN;
  logic [XLEN-1:0] qs, rs;

  always_comb begin
    qs    = neg_q ? (~quo + {{(XLEN-1){1'b0}}, 1'b1}) : quo;
    rs    = neg_r ? (~rem + {{(XLEN-1){1'b0}}, 1'b1}) : rem;
    q_out = word ? {{XW{qs[WLEN-1]}}, qs[WLEN-1:0]} : qs;
    r_out = word ? {{XW{rs[WLEN-1]}}, rs[WLEN-1:0]} : rs;
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            op_rem,
  input  logic            op_signed,
  input  logic            word_mode,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int CW = $clog2(XLEN);
  localparam logic [XLEN-1:0] MINV = {1'b1, {(XLEN-1){1'b0}}};

  div_state_t      state;
  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] lat_a, lat_b, q_keep, r_keep;
  logic            lat_sgn, lat_word, lat_rem, nq_q, nr_q, div0_q, keep_ok;

  logic [XLEN-1:0] dvd_mag, dvs_mag, quo, rem, q_fix, r_fix;
  logic            neg_q, neg_r, zero_dvs, hit, load;

  div_prep #(.XLEN(XLEN), .WLEN(WLEN)) u_prep (
    .a(opa), .b(opb), .sgn(op_signed), .word(word_mode),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
    .neg_q(neg_q), .neg_r(neg_r), .zero_dvs(zero_dvs)
  );

  assign hit  = keep_ok && (opa == lat_a) && (opb == lat_b) &&
                (op_signed == lat_sgn) && (word_mode == lat_word);
  assign load = (state == ST_IDLE) && start && !hit;

  div_core #(.XLEN(XLEN)) u_core (
    .clk(clk), .rst(rst), .load(load), .step(state == ST_RUN),
    .dvd(dvd_mag), .dvs(dvs_mag), .quo(quo), .rem(rem)
  );

  div_fix #(.XLEN(XLEN), .WLEN(WLEN)) u_fix (
    .quo(quo), .rem(rem), .neg_q(nq_q), .neg_r(nr_q), .word(lat_word),
    .q_out(q_fix), .r_out(r_fix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lat_a    <= '0;
      lat_b    <= '0;
      lat_sgn  <= 1'b0;
      lat_word <= 1'b0;
      lat_rem  <= 1'b0;
      nq_q     <= 1'b0;
      nr_q     <= 1'b0;
      div0_q   <= 1'b0;
      keep_ok  <= 1'b0;
      q_keep   <= '0;
      r_keep   <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          lat_rem <= op_rem;
          if (hit) begin
            result <= op_rem ? r_keep : q_keep;
            done   <= 1'b1;
          end else begin
            lat_a    <= opa;
            lat_b    <= opb;
            lat_sgn  <= op_signed;
            lat_word <= word_mode;
            nq_q     <= neg_q;
            nr_q     <= neg_r;
            div0_q   <= zero_dvs;
            keep_ok  <= 1'b0;
            done     <= 1'b0;
            busy     <= 1'b1;
            cnt      <= word_mode ? CW'(WLEN-1) : CW'(XLEN-1);
            state    <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (cnt == '0) state <= ST_FIX;
          else           cnt   <= cnt - 1'b1;
        end
        ST_FIX: begin
          q_keep  <= q_fix;
          r_keep  <= r_fix;
          result  <= lat_rem ? r_fix : q_fix;
          done    <= 1'b1;
          busy    <= 1'b0;
          keep_ok <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: handshake outputs are exclusive
  a_r7_busy_excl_done: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);
  // R9: an idle unit with no request keeps its answer
  a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(result) && $stable(done)));
  // R8: captured operands stay put while a division runs
  a_r8_capture_stable: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(lat_a) && $stable(lat_b)));
  // R8, R10: an accepted request always leaves the unit busy or done
  a_r10_accept_moves: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy || done));
  // R3: full-width zero divisor gives an all-ones quotient
  a_r3_div0_quotient: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIX && div0_q && !lat_rem && !lat_word) |=> (result == '1));
  // R4: signed overflow quotient equals the dividend
  a_r4_overflow_quotient: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIX && lat_sgn && !lat_word && !lat_rem &&
     lat_a == MINV && lat_b == '1) |=> (result == lat_a));
endmodule

// File: tb/sim_seq_divider.sv
module sim_seq_divider;
  localparam int XL = 8;
  localparam int WL = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0, op_rem = 1'b0, op_signed = 1'b0, word_mode = 1'b0;
  logic [XL-1:0] opa = '0, opb = '0;
  logic          busy, done;
  logic [XL-1:0] result;

  int compared = 0;
  int mismatched = 0;

  seq_divider #(.XLEN(XL), .WLEN(WL)) u0 (
    .clk(clk), .rst(rst), .start(start), .op_rem(op_rem),
    .op_signed(op_signed), .word_mode(word_mode), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .result(result)
  );

  always #2 clk = ~clk;

  function automatic logic [XL-1:0] model(input logic [XL-1:0] a, b,
                                           input logic rem, sgn, wd);
    int w;
    longint av, bv, q, r;
    logic [XL-1:0] raw;
    w  = wd ? WL : XL;
    av = longint'(a) & ((longint'(1) << w) - 1);
    bv = longint'(b) & ((longint'(1) << w) - 1);
    if (sgn && av >= (longint'(1) << (w-1))) av = av - (longint'(1) << w);
    if (sgn && bv >= (longint'(1) << (w-1))) bv = bv - (longint'(1) << w);
    if (bv == 0) begin
      q = -1; r = av;
    end else if (sgn && av == -(longint'(1) << (w-1)) && bv == -1) begin
      q = av; r = 0;
    end else begin
      q = av / bv; r = av % bv;
    end
    raw = rem ? r[XL-1:0] : q[XL-1:0];
    return wd ? {{(XL-WL){raw[WL-1]}}, raw[WL-1:0]} : raw;
  endfunction

  function automatic string tag_of(input logic [XL-1:0] a, b, input logic sgn, wd);
    if (wd && b[WL-1:0] == '0) return "R6";
    if (wd) return "R5";
    if (b == '0) return "R3";
    if (sgn && a == 8'h80 && b == 8'hff) return "R4";
    if (sgn) return "R2";
    return "R1";
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [XL-1:0] a, b, input logic rem, sgn, wd,
                        input int exp_lat);
    int lat;
    logic [XL-1:0] exp;
    @(negedge clk);
    opa = a; opb = b; op_rem = rem; op_signed = sgn; word_mode = wd; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    exp = model(a, b, rem, sgn, wd);
    check(result == exp, tag_of(a, b, sgn, wd), longint'(result), longint'(exp));
    if (exp_lat > 0)
      check(lat == exp_lat, (exp_lat == 1) ? "R10 latency" : "R7 latency",
            longint'(lat), longint'(exp_lat));
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [XL-1:0] blist [12];
    logic [XL-1:0] held;
    int lat;
    blist = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h07, 8'h0d, 8'h7f,
              8'h80, 8'h81, 8'hfe, 8'hff};

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R7: reset state
    check(busy == 1'b0 && done == 1'b0, "R7 reset flags", longint'({busy, done}), 0);
    check(result == '0, "R7 reset result", longint'(result), 0);

    // R4 explicit corners, full and word
    run_op(8'h80, 8'hff, 1'b0, 1'b1, 1'b0, 10);
    run_op(8'h80, 8'hff, 1'b1, 1'b1, 1'b0, 1);
    run_op(8'h38, 8'h9f, 1'b0, 1'b1, 1'b1, 6);
    run_op(8'h38, 8'h9f, 1'b1, 1'b1, 1'b1, 1);

    // R1 R2 R3 R4 R10: full-width sweep, quotient then remainder on each pair
    for (int ia = 0; ia < 256; ia += 5) begin
      for (int j = 0; j < 12; j++) begin
        for (int k = 0; k < 4; k++) begin
          run_op(8'(ia), blist[j], k[0], k[1], 1'b0, k[0] ? 1 : 10);
        end
      end
    end

    // R5 R6: word-mode sweep with junk in the unused upper bits
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        for (int k = 0; k < 4; k++) begin
          run_op({4'(ia * 7 + 3), 4'(ia)}, {4'(ib * 5 + 9), 4'(ib)},
                 k[0], k[1], 1'b1, k[0] ? 1 : 6);
        end
      end
    end

    // R10: a changed word flag alone forces a full run
    run_op(8'h5a, 8'h13, 1'b0, 1'b0, 1'b0, 10);
    run_op(8'h5a, 8'h13, 1'b0, 1'b0, 1'b1, 6);
    @(negedge clk);
    check(busy == 1'b0, "R10 busy low on hit path", longint'(busy), 0);

    // R8: start mid-run and during the fix-up cycle is ignored
    @(negedge clk);
    opa = 8'hc3; opb = 8'h07; op_rem = 1'b0; op_signed = 1'b1; word_mode = 1'b0;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(busy == 1'b1 && done == 1'b0, "R7 busy after accept",
          longint'({busy, done}), 2);
    opa = 8'h11; opb = 8'h02; op_rem = 1'b1;
    lat = 1;
    for (int c = 0; c < 9; c++) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (c == 1) begin
        opa = 8'h24;
      end
    end
    start = 1'b0;
    check(lat == 10 && done == 1'b1, "R8 latency unchanged", longint'(lat), 10);
    check(result == model(8'hc3, 8'h07, 1'b0, 1'b1, 1'b0), "R8 ignored start",
          longint'(result), longint'(model(8'hc3, 8'h07, 1'b0, 1'b1, 1'b0)));

    // R9: outputs hold while inputs wander without start
    held = result;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      opa = 8'(c * 37); opb = 8'(c * 11 + 1); op_rem = c[0]; word_mode = c[1];
    end
    @(negedge clk);
    check(result == held && done == 1'b1 && busy == 1'b0, "R9 hold",
          longint'(result), longint'(held));

    finish_up();
  end
endmodule